// File: doc/BRIEF.md
# Coalescing Atomic Writeback Queue

This block sits between the atomic compute stage of a cache bank and the write port of the data array. Each completed atomic result arrives as a line address, a data word and a byte-enable mask, and waits here until the array can take it. A result whose line is already queued is folded into that entry, so the array only ever receives the newest value for a line. A result for a line that is not queued takes a free entry behind those already waiting. Queued lines are unique, and entries leave in arrival order.

Reads that follow an atomic can present their line address on a lookup port. If that line is queued, the block returns the pending word and mask, so the reader does not use the stale array contents. The push and drain ports are valid/ready streams. The drain port has no link to any pipeline stall signal, so the queue can always empty and no deadlock cycle forms through it. A push is refused only when the queue is full and there is nothing to merge into.

Back-pressure rules: `drain_valid` is high whenever an entry is queued. The head address stays fixed until the array accepts it. The head data may change while the head waits, because a same-line push can merge into it. `push_ready` is combinational and depends on `drain_ready` in the same cycle. The compute stage can therefore push into a full queue in the cycle the head leaves.

Top module: `atomic_wb_queue`

## Requirements
- R1: The queue holds DEPTH entries (default 2). `full` is high exactly when all DEPTH entries are occupied. `push_ready` is low only when the queue is full, the pushed line is not queued, and no drain completes in that cycle.
- R2: An accepted push whose line matches a queued entry merges into that entry in place. Each byte i whose bit i of `push_be` is 1 takes bits [8i+7:8i] of `push_data`, and every other byte keeps its stored value. The entry's mask becomes the OR of the old and new masks, and occupancy does not change, so queued lines stay unique.
- R3: An accepted push for a line that is not queued is stored as given (full word and mask) in a new entry behind every pending entry. No pending entry is altered or dropped.
- R4: Entries drain in first-in first-out order. `drain_addr`, `drain_data` and `drain_be` show the oldest entry, and one entry is removed on each cycle with `drain_valid` and `drain_ready` both high.
- R5: `fwd_hit` is high when `fwd_addr` equals a queued line. `fwd_data` and `fwd_be` then show that entry's current contents. A push becomes visible to lookups from the next cycle.
- R6: While `drain_valid` is high and `drain_ready` is low, `drain_valid` stays high and `drain_addr` stays unchanged.
- R7: A push and a drain in the same cycle both take effect. When the push takes a new entry, occupancy stays the same.
- R8: A push to the line of the head entry in the cycle that the head drains does not merge into the departing entry. The array receives the old head contents, and a new entry holds the merged value (the R2 rule applied to the old head) at the tail.
- R9: After reset the queue is empty: `drain_valid`, `full` and `fwd_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Compute stage offers a result |
| push_ready | output | 1 | Queue accepts the offered result |
| push_addr | input | ADDR_W | Line address of the result |
| push_data | input | DATA_W | Result word |
| push_be | input | DATA_W/8 | Byte enables of the result |
| drain_valid | output | 1 | Head entry available for the array |
| drain_ready | input | 1 | Array write port takes the head |
| drain_addr | output | ADDR_W | Head line address |
| drain_data | output | DATA_W | Head word |
| drain_be | output | DATA_W/8 | Head byte enables |
| fwd_addr | input | ADDR_W | Lookup line address |
| fwd_hit | output | 1 | Lookup line is queued |
| fwd_data | output | DATA_W | Queued word for the lookup line |
| fwd_be | output | DATA_W/8 | Queued byte enables for the lookup line |
| full | output | 1 | All entries occupied |

## Verification
The hardest case to reach is the collision in R8. It needs a push to the head's line in exactly the cycle the array accepts that head, and the same cycle also exercises R7 when the queue is full. Directed steps build a stalled two-entry queue, merge into both entries, and then raise `drain_ready` together with a push to the head line. A long random phase follows with only four line addresses and changing drain acceptance rates, so collisions with the head, with the tail and with a departing entry occur many times against a behavioural queue model.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
  // What an accepted (or absent) push does to the queue this cycle
  typedef enum logic [1:0] {
    ACT_IDLE,          // no push accepted
    ACT_MERGE,         // fold into a resident entry in place
    ACT_APPEND,        // new line, new tail entry
    ACT_APPEND_MERGED  // head line while head leaves: merged copy to tail
  } push_act_e;
endpackage

// File: rtl/wbq_byte_merge.sv
module wbq_byte_merge #(
  parameter int DATA_W = 32,
  localparam int BE_W = DATA_W / 8
) (
  input  logic [DATA_W-1:0] old_data,
  input  logic [BE_W-1:0]   old_be,
  input  logic [DATA_W-1:0] new_data,
  input  logic [BE_W-1:0]   new_be,
  output logic [DATA_W-1:0] out_data,
  output logic [BE_W-1:0]   out_be
);
  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    assign out_data[8*b +: 8] = new_be[b] ? new_data[8*b +: 8] : old_data[8*b +: 8];
  end
  assign out_be = old_be | new_be;
endmodule

// File: rtl/wbq_line_match.sv
module wbq_line_match #(
  parameter int DEPTH  = 2,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [ADDR_W-1:0] key,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] q_addr [DEPTH],
  input  logic [DATA_W-1:0] q_data [DEPTH],
  input  logic [BE_W-1:0]   q_be   [DEPTH],
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [DATA_W-1:0] hit_data,
  output logic [BE_W-1:0]   hit_be
);
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = (CNT_W'(i) < count) && (q_addr[i] == key);
  end

  assign hit = |match;

  // Lines are unique, so at most one bit of match is set: an OR mux suffices
  always_comb begin
    hit_idx  = '0;
    hit_data = '0;
    hit_be   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) begin
        hit_idx  = hit_idx | IDX_W'(i);
        hit_data = hit_data | q_data[i];
        hit_be   = hit_be | q_be[i];
      end
    end
  end
endmodule

// File: rtl/atomic_wb_queue.sv
module atomic_wb_queue
  import wbq_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic [BE_W-1:0]   push_be,
  output logic              drain_valid,
  input  logic              drain_ready,
  output logic [ADDR_W-1:0] drain_addr,
  output logic [DATA_W-1:0] drain_data,
  output logic [BE_W-1:0]   drain_be,
  input  logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_hit,
  output logic [DATA_W-1:0] fwd_data,
  output logic [BE_W-1:0]   fwd_be,
  output logic              full
);
  // Entry 0 is always the oldest; entries below count are occupied
  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [DATA_W-1:0] q_data [DEPTH];
  logic [BE_W-1:0]   q_be   [DEPTH];
  logic [CNT_W-1:0]  count;

  logic [ADDR_W-1:0] n_addr [DEPTH];
  logic [DATA_W-1:0] n_data [DEPTH];
  logic [BE_W-1:0]   n_be   [DEPTH];
  logic [CNT_W-1:0]  n_count;

  logic              p_hit;
  logic [IDX_W-1:0]  p_idx;
  logic [DATA_W-1:0] p_old_data, m_data;
  logic [BE_W-1:0]   p_old_be, m_be;
  logic              drain_fire, push_fire;
  push_act_e         act;

  // Lookup for the push side (merge target)
  wbq_line_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_push_match (
    .key(push_addr), .count(count), .q_addr(q_addr), .q_data(q_data), .q_be(q_be),
    .hit(p_hit), .hit_idx(p_idx), .hit_data(p_old_data), .hit_be(p_old_be)
  );

  // Lookup for dependent reads; registered state only
  logic [IDX_W-1:0] f_idx_unused;
  wbq_line_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd_match (
    .key(fwd_addr), .count(count), .q_addr(q_addr), .q_data(q_data), .q_be(q_be),
    .hit(fwd_hit), .hit_idx(f_idx_unused), .hit_data(fwd_data), .hit_be(fwd_be)
  );

  wbq_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .old_data(p_old_data), .old_be(p_old_be),
    .new_data(push_data),  .new_be(push_be),
    .out_data(m_data),     .out_be(m_be)
  );

  assign full        = (count == CNT_W'(DEPTH));
  assign drain_valid = (count != '0);
  assign drain_fire  = drain_valid && drain_ready;
  assign push_ready  = !full || p_hit || drain_fire;
  assign push_fire   = push_valid && push_ready;

  assign drain_addr = q_addr[0];
  assign drain_data = q_data[0];
  assign drain_be   = q_be[0];

  always_comb begin
    act = ACT_IDLE;
    if (push_fire) begin
      if (!p_hit)                             act = ACT_APPEND;
      else if (p_idx == '0 && drain_fire)     act = ACT_APPEND_MERGED;
      else                                    act = ACT_MERGE;
    end
  end

  always_comb begin
    logic [CNT_W-1:0] base;
    n_addr = q_addr;
    n_data = q_data;
    n_be   = q_be;
    // 1) in-place merge
    for (int i = 0; i < DEPTH; i++) begin
      if (act == ACT_MERGE && p_idx == IDX_W'(i)) begin
        n_data[i] = m_data;
        n_be[i]   = m_be;
      end
    end
    // 2) remove head
    base = count;
    if (drain_fire) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        n_addr[i] = n_addr[i+1];
        n_data[i] = n_data[i+1];
        n_be[i]   = n_be[i+1];
      end
      base = count - CNT_W'(1);
    end
    // 3) append at the tail
    n_count = base;
    if (act == ACT_APPEND || act == ACT_APPEND_MERGED) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (base == CNT_W'(i)) begin
          n_addr[i] = push_addr;
          n_data[i] = (act == ACT_APPEND) ? push_data : m_data;
          n_be[i]   = (act == ACT_APPEND) ? push_be   : m_be;
        end
      end
      n_count = base + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_addr[i] <= '0;
        q_data[i] <= '0;
        q_be[i]   <= '0;
      end
    end else begin
      count  <= n_count;
      q_addr <= n_addr;
      q_data <= n_data;
      q_be   <= n_be;
    end
  end
endmodule

// File: rtl/atomic_wb_queue_chk.sv
module atomic_wb_queue_chk #(
  parameter int DEPTH  = 2,
  parameter int ADDR_W = 26,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_valid,
  input logic              push_ready,
  input logic [ADDR_W-1:0] push_addr,
  input logic              drain_valid,
  input logic              drain_ready,
  input logic [ADDR_W-1:0] drain_addr,
  input logic [CNT_W-1:0]  count,
  input logic [ADDR_W-1:0] q_addr [DEPTH]
);
  logic line_present;
  always_comb begin
    line_present = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (int'(count) > i && q_addr[i] == push_addr) line_present = 1'b1;
  end

  // R1: occupancy never exceeds the capacity
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R2: two occupied entries never hold the same line
  for (genvar i = 0; i < DEPTH; i++) begin : g_a
    for (genvar j = i + 1; j < DEPTH; j++) begin : g_b
      assert_unique_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) > j) |-> (q_addr[i] != q_addr[j]));
    end
  end

  // R6: a refused head keeps its line and stays offered
  assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !drain_ready) |=> (drain_valid && $stable(drain_addr)));

  // R7: a new-line push grows occupancy by one, less any drain that cycle
  assert_append_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && !line_present) |=>
      (int'(count) == int'($past(count)) + 1 - ($past(drain_valid && drain_ready) ? 1 : 0)));
endmodule

bind atomic_wb_queue atomic_wb_queue_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/atomic_wb_queue_test.sv
module atomic_wb_queue_test;
  localparam int DEPTH  = 2;
  localparam int ADDR_W = 26;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              push_valid = 1'b0;
  logic              push_ready;
  logic [ADDR_W-1:0] push_addr = '0;
  logic [DATA_W-1:0] push_data = '0;
  logic [BE_W-1:0]   push_be = '0;
  logic              drain_valid;
  logic              drain_ready = 1'b0;
  logic [ADDR_W-1:0] drain_addr;
  logic [DATA_W-1:0] drain_data;
  logic [BE_W-1:0]   drain_be;
  logic [ADDR_W-1:0] fwd_addr = '0;
  logic              fwd_hit;
  logic [DATA_W-1:0] fwd_data;
  logic [BE_W-1:0]   fwd_be;
  logic              full;

  always #5 clk = ~clk;

  atomic_wb_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    logic [BE_W-1:0]   b;
  } ent_t;

  ent_t  mq[$];
  int    n_chk = 0;
  int    n_bad = 0;
  string phase = "R9";

  function automatic ent_t fold(ent_t e, logic [DATA_W-1:0] d, logic [BE_W-1:0] b);
    ent_t r = e;
    for (int k = 0; k < BE_W; k++) if (b[k]) r.d[8*k +: 8] = d[8*k +: 8];
    r.b = e.b | b;
    return r;
  endfunction

  function automatic int find(logic [ADDR_W-1:0] a);
    for (int k = 0; k < mq.size(); k++) if (mq[k].a == a) return k;
    return -1;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare before posedge, advance model
  task automatic step(logic pv, logic [ADDR_W-1:0] pa, logic [DATA_W-1:0] pd,
                      logic [BE_W-1:0] pb, logic dr, logic [ADDR_W-1:0] fa);
    int  pi, fi;
    logic e_dv, e_full, e_pr, dfire, pfire;
    ent_t app;
    logic do_app;
    @(negedge clk);
    push_valid = pv; push_addr = pa; push_data = pd; push_be = pb;
    drain_ready = dr; fwd_addr = fa;
    #2;
    e_dv   = (mq.size() > 0);
    e_full = (mq.size() == DEPTH);
    pi     = find(pa);
    fi     = find(fa);
    dfire  = e_dv && dr;
    e_pr   = !e_full || (pi >= 0) || dfire;
    chk(phase, "drain_valid", 64'(drain_valid), 64'(e_dv));
    if (e_dv) begin
      chk(phase, "drain_addr", 64'(drain_addr), 64'(mq[0].a));
      chk(phase, "drain_data", 64'(drain_data), 64'(mq[0].d));
      chk(phase, "drain_be",   64'(drain_be),   64'(mq[0].b));
    end
    chk("R1", "full",       64'(full),       64'(e_full));
    chk("R1", "push_ready", 64'(push_ready), 64'(e_pr));
    chk("R5", "fwd_hit",    64'(fwd_hit),    64'(fi >= 0));
    if (fi >= 0) begin
      chk("R5", "fwd_data", 64'(fwd_data), 64'(mq[fi].d));
      chk("R5", "fwd_be",   64'(fwd_be),   64'(mq[fi].b));
    end
    pfire  = pv && e_pr;
    do_app = 1'b0;
    app    = '{a: pa, d: pd, b: pb};
    if (pfire) begin
      if (pi < 0) do_app = 1'b1;
      else if (pi == 0 && dfire) begin app = fold(mq[0], pd, pb); do_app = 1'b1; end
      else mq[pi] = fold(mq[pi], pd, pb);
    end
    if (dfire) void'(mq.pop_front());
    if (do_app) mq.push_back(app);
  endtask

  task automatic idle(logic dr, logic [ADDR_W-1:0] fa);
    step(1'b0, '0, '0, '0, dr, fa);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  localparam logic [ADDR_W-1:0] LA = 26'd5, LB = 26'd9, LC = 26'd12, LD = 26'd7;

  initial begin : stim
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: empty after reset
    phase = "R9";
    idle(1'b0, LA); idle(1'b1, LB);
    // R3: two new lines queue behind each other, stalled
    phase = "R3";
    step(1'b1, LA, 32'h1111_1111, 4'hF, 1'b0, LA);
    step(1'b1, LB, 32'h2222_2222, 4'h3, 1'b0, LA);
    idle(1'b0, LB);
    // R1: full queue refuses an unknown line
    phase = "R1";
    step(1'b1, LC, 32'h3333_3333, 4'hF, 1'b0, LC);
    idle(1'b0, LC);
    // R2: merges into head and tail while stalled
    phase = "R2";
    step(1'b1, LA, 32'hAABB_CCDD, 4'h5, 1'b0, LA);
    step(1'b1, LB, 32'h4455_6677, 4'hC, 1'b0, LA);
    idle(1'b0, LB);
    // R6: held head
    phase = "R6";
    for (int k = 0; k < 4; k++) idle(1'b0, (k % 2) ? LA : LB);
    // R8: push to the departing head line
    phase = "R8";
    step(1'b1, LA, 32'h9988_7766, 4'h2, 1'b1, LA);
    idle(1'b0, LA);
    // R7: push new line while full and draining
    phase = "R7";
    step(1'b1, LD, 32'h5A5A_5A5A, 4'h9, 1'b1, LD);
    idle(1'b0, LD);
    // R4: drain out in order
    phase = "R4";
    for (int k = 0; k < 4; k++) idle(1'b1, LA);
    // Random phase: four lines, varying drain acceptance
    for (int seg = 0; seg < 8; seg++) begin
      int pct = 15 + seg * 11;
      for (int k = 0; k < 500; k++) begin
        step(($urandom_range(0, 99) < 65),
             ADDR_W'($urandom_range(0, 3) + 8),
             $urandom(),
             BE_W'($urandom_range(0, 15)),
             ($urandom_range(0, 99) < pct),
             ADDR_W'($urandom_range(0, 4) + 8));
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule